// File: doc/BRIEF.md
# Dual-Channel Capture/Compare Timer

A 16-bit up-counter with two channel registers. A mode bit per channel, changeable at run time, makes each channel either a capture register or a compare register. In capture mode the channel takes a snapshot of the running count when its input pin shows the selected edge. In compare mode the channel holds a value D. It pulses its interrupt line and inverts its output pin in the cycle the count becomes D+1.

The counter advances on every clock, or on selected edges of an event input. It reports wrap-around through a sticky overflow flag. Its value can be read at any time. Software reaches all state through a synchronous write port and a registered read port. The register map is: 0 control, 1 option, 2 count (read-only), 3 channel 0, 4 channel 1.

Top module: `cct_timer`

## Requirements
- R1: After reset, all registers read 0, and rd_data, cmp_out and cmp_irq are 0.
- R2: While control bit 0 (run) is 1 and control bit 1 (event mode) is 0, the counter adds 1 every clock, wrapping modulo 2^16. Reading address 2 returns the count held before the read edge.
- R3: While run is 0, the counter is held at 0. One clock after run becomes 0, both cmp_out bits are 0.
- R4: A channel in compare mode (option bit i = 0) with value D pulses cmp_irq[i] for exactly one cycle, and inverts cmp_out[i], in the cycle the count advances to (D+1) mod 2^16. For D = 0xFFFF this is the wrap to 0.
- R5: A channel in capture mode (option bit i = 1) stores the count that is present two clocks after a valid change on cap_pin[i]. The input passes a two-flop synchronizer, and the stored value is readable at address 3+i.
- R6: Edge select encoding is 00 none, 01 rising, 10 falling, 11 both. Channel 0 uses option bits [3:2], channel 1 uses bits [5:4], and the event input uses control bits [3:2].
- R7: In event mode with run set, the counter adds 1 once per valid edge of evt_pin and holds otherwise.
- R8: Option bit 15 is an overflow flag that is set when the counter wraps from 0xFFFF. Writing 0 to it clears it and writing 1 has no effect. A wrap in the same cycle as a clearing write leaves it set.
- R9: When a capture and a software write hit the same channel register in one cycle, the captured count is kept.
- R10: A capture-mode channel never pulses cmp_irq. A compare-mode channel ignores edges on its cap_pin.
- R11: A written register value reads back unchanged, one clock after rd_en is sampled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Write address |
| wr_data | input | 16 | Write data |
| rd_en | input | 1 | Register read strobe |
| rd_addr | input | 3 | Read address |
| rd_data | output | 16 | Registered read data |
| evt_pin | input | 1 | External event count input |
| cap_pin | input | 2 | Per-channel capture inputs |
| cmp_out | output | 2 | Per-channel compare toggle outputs |
| cmp_irq | output | 2 | Per-channel compare match pulses |

## Verification
Two pairs of functions can land in the same cycle.

The first pair is a capture and a software write to the same channel register. The bench changes a capture pin and issues the write on the third edge after the change, which is exactly when the synchronized edge is latched. It then reads the register back and expects the captured count, not the written word.

The second pair is a counter wrap and a clearing write to the overflow flag. The bench runs the counter to 0xFFFF, places the clearing write on the wrapping edge, and expects the flag to read 1. In the same cycle it expects the compare pulse of a channel programmed to 0xFFFF.

// File: rtl/cct_pkg.sv
package cct_pkg;

    typedef enum logic [1:0] {
        EDGE_NONE = 2'b00,
        EDGE_RISE = 2'b01,
        EDGE_FALL = 2'b10,
        EDGE_BOTH = 2'b11
    } edge_sel_e;

    localparam int ADR_CTRL    = 0;
    localparam int ADR_OPT     = 1;
    localparam int ADR_CNT     = 2;
    localparam int ADR_CH_BASE = 3;

    localparam int CTRL_W = 4;

    // control word layout, MSB first: event edge select, event mode, run
    typedef struct packed {
        edge_sel_e evt_sel;
        logic      evt_mode;
        logic      run;
    } ctrl_t;

    function automatic logic edge_match(edge_sel_e sel, logic prev, logic cur);
        case (sel)
            EDGE_RISE: return cur & ~prev;
            EDGE_FALL: return prev & ~cur;
            EDGE_BOTH: return cur ^ prev;
            default:   return 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/cct_edge_det.sv
module cct_edge_det #(
    parameter int STAGES = 2
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                pin,
    input  cct_pkg::edge_sel_e  sel,
    output logic                hit
);
    logic [STAGES:0] chain;

    always_ff @(posedge clk) begin
        if (rst) chain <= '0;
        else     chain <= {chain[STAGES-1:0], pin};
    end

    // the two oldest stages form the previous/current pair
    assign hit = cct_pkg::edge_match(sel, chain[STAGES], chain[STAGES-1]);
endmodule

// File: rtl/cct_counter.sv
module cct_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic             evt_mode,
    input  logic             evt_hit,
    input  logic             ovf_clr,
    output logic [CNT_W-1:0] cnt,
    output logic [CNT_W-1:0] cnt_nxt,
    output logic             adv,
    output logic             ovf
);
    logic wrap;

    assign adv     = run & (evt_mode ? evt_hit : 1'b1);
    assign cnt_nxt = CNT_W'(cnt + 1'b1);
    assign wrap    = adv & (&cnt);

    always_ff @(posedge clk) begin
        if (rst)       cnt <= '0;
        else if (!run) cnt <= '0;
        else if (adv)  cnt <= cnt_nxt;
    end

    // a wrap outranks a clearing write in the same cycle
    always_ff @(posedge clk) begin
        if (rst)          ovf <= 1'b0;
        else if (wrap)    ovf <= 1'b1;
        else if (ovf_clr) ovf <= 1'b0;
    end
endmodule

// File: rtl/cct_channel.sv
module cct_channel #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic             cap_mode,
    input  logic             cap_hit,
    input  logic             wr_hit,
    input  logic [CNT_W-1:0] wr_data,
    input  logic             adv,
    input  logic [CNT_W-1:0] cnt,
    input  logic [CNT_W-1:0] cnt_nxt,
    output logic [CNT_W-1:0] val,
    output logic             out,
    output logic             irq
);
    logic match;

    assign match = ~cap_mode & adv & (cnt_nxt == CNT_W'(val + 1'b1));

    // capture outranks software write
    always_ff @(posedge clk) begin
        if (rst)                    val <= '0;
        else if (cap_mode & cap_hit) val <= cnt;
        else if (wr_hit)            val <= wr_data;
    end

    always_ff @(posedge clk) begin
        if (rst) irq <= 1'b0;
        else     irq <= match;
    end

    always_ff @(posedge clk) begin
        if (rst)        out <= 1'b0;
        else if (!run)  out <= 1'b0;
        else if (match) out <= ~out;
    end
endmodule

// File: rtl/cct_timer.sv
module cct_timer #(
    parameter int CNT_W       = 16,
    parameter int N_CH        = 2,
    parameter int ADDR_W      = 3,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [CNT_W-1:0]  wr_data,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [CNT_W-1:0]  rd_data,
    input  logic              evt_pin,
    input  logic [N_CH-1:0]   cap_pin,
    output logic [N_CH-1:0]   cmp_out,
    output logic [N_CH-1:0]   cmp_irq
);
    import cct_pkg::*;

    localparam int OVF_BIT = CNT_W - 1;
    localparam int SEL_LSB = N_CH;

    ctrl_t              ctrl;
    logic [N_CH-1:0]    cap_mode;
    edge_sel_e          cap_sel [N_CH];
    logic [CNT_W-1:0]   cnt_q, cnt_nxt;
    logic               cnt_adv, ovf_q, evt_hit, ovf_clr;
    logic [N_CH-1:0]    cap_hit, ch_wr;
    logic [CNT_W-1:0]   ch_val [N_CH];
    logic [CNT_W-1:0]   opt_word, rd_mux;

    assign ovf_clr = wr_en && (wr_addr == ADDR_W'(ADR_OPT)) && !wr_data[OVF_BIT];

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl     <= '0;
            cap_mode <= '0;
            for (int i = 0; i < N_CH; i++) cap_sel[i] <= EDGE_NONE;
        end else if (wr_en) begin
            if (wr_addr == ADDR_W'(ADR_CTRL))
                ctrl <= ctrl_t'(wr_data[CTRL_W-1:0]);
            if (wr_addr == ADDR_W'(ADR_OPT)) begin
                cap_mode <= wr_data[N_CH-1:0];
                for (int i = 0; i < N_CH; i++)
                    cap_sel[i] <= edge_sel_e'(wr_data[SEL_LSB+2*i +: 2]);
            end
        end
    end

    cct_edge_det #(.STAGES(SYNC_STAGES)) u_evt_det (
        .clk(clk), .rst(rst), .pin(evt_pin), .sel(ctrl.evt_sel), .hit(evt_hit)
    );

    cct_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk(clk), .rst(rst), .run(ctrl.run), .evt_mode(ctrl.evt_mode),
        .evt_hit(evt_hit), .ovf_clr(ovf_clr), .cnt(cnt_q), .cnt_nxt(cnt_nxt),
        .adv(cnt_adv), .ovf(ovf_q)
    );

    for (genvar g = 0; g < N_CH; g++) begin : g_ch
        assign ch_wr[g] = wr_en && (wr_addr == ADDR_W'(ADR_CH_BASE + g));

        cct_edge_det #(.STAGES(SYNC_STAGES)) u_cap_det (
            .clk(clk), .rst(rst), .pin(cap_pin[g]), .sel(cap_sel[g]), .hit(cap_hit[g])
        );

        cct_channel #(.CNT_W(CNT_W)) u_ch (
            .clk(clk), .rst(rst), .run(ctrl.run), .cap_mode(cap_mode[g]),
            .cap_hit(cap_hit[g]), .wr_hit(ch_wr[g]), .wr_data(wr_data),
            .adv(cnt_adv), .cnt(cnt_q), .cnt_nxt(cnt_nxt),
            .val(ch_val[g]), .out(cmp_out[g]), .irq(cmp_irq[g])
        );
    end

    always_comb begin
        opt_word = '0;
        opt_word[N_CH-1:0] = cap_mode;
        for (int i = 0; i < N_CH; i++) opt_word[SEL_LSB+2*i +: 2] = cap_sel[i];
        opt_word[OVF_BIT] = ovf_q;
    end

    always_comb begin
        rd_mux = '0;
        if (rd_addr == ADDR_W'(ADR_CTRL)) rd_mux = CNT_W'(ctrl);
        if (rd_addr == ADDR_W'(ADR_OPT))  rd_mux = opt_word;
        if (rd_addr == ADDR_W'(ADR_CNT))  rd_mux = cnt_q;
        for (int i = 0; i < N_CH; i++)
            if (rd_addr == ADDR_W'(ADR_CH_BASE + i)) rd_mux = ch_val[i];
    end

    always_ff @(posedge clk) begin
        if (rst)        rd_data <= '0;
        else if (rd_en) rd_data <= rd_mux;
    end
endmodule

// File: rtl/cct_timer_chk.sv
module cct_timer_chk #(
    parameter int CNT_W = 16,
    parameter int N_CH  = 2
) (
    input logic             clk,
    input logic             rst,
    input logic             run,
    input logic             evt_mode,
    input logic             adv,
    input logic [CNT_W-1:0] cnt,
    input logic             ovf,
    input logic [N_CH-1:0]  cmp_out,
    input logic [N_CH-1:0]  cmp_irq
);
    // R3
    run_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !run |=> (cnt == '0 && cmp_out == '0));

    // R2
    count_step_chk: assert property (@(posedge clk) disable iff (rst)
        (run && !evt_mode) |=> cnt == CNT_W'($past(cnt) + 1'b1));

    // R8
    ovf_set_chk: assert property (@(posedge clk) disable iff (rst)
        (adv && (&cnt)) |=> ovf);

    for (genvar g = 0; g < N_CH; g++) begin : g_chk
        // R4
        irq_single_chk: assert property (@(posedge clk) disable iff (rst)
            cmp_irq[g] |=> !cmp_irq[g]);

        // R4
        irq_toggle_chk: assert property (@(posedge clk) disable iff (rst)
            cmp_irq[g] |-> cmp_out[g] != $past(cmp_out[g]));
    end
endmodule

bind cct_timer cct_timer_chk #(.CNT_W(CNT_W), .N_CH(N_CH)) u_chk (
    .clk(clk), .rst(rst), .run(ctrl.run), .evt_mode(ctrl.evt_mode),
    .adv(cnt_adv), .cnt(cnt_q), .ovf(ovf_q), .cmp_out(cmp_out), .cmp_irq(cmp_irq)
);

// File: tb/sim_cct_timer.sv
`timescale 1ns/1ps
module sim_cct_timer;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_addr = '0;
    logic [15:0] wr_data = '0;
    logic        rd_en = 1'b0;
    logic [2:0]  rd_addr = '0;
    logic [15:0] rd_data;
    logic        evt_pin = 1'b0;
    logic [1:0]  cap_pin = '0;
    logic [1:0]  cmp_out, cmp_irq;

    int tests = 0;
    int fails = 0;
    int cyc = 0;
    int r = 0;

    cct_timer u0 (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data), .evt_pin(evt_pin),
        .cap_pin(cap_pin), .cmp_out(cmp_out), .cmp_irq(cmp_irq)
    );

    always #10 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input int a, input logic [15:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = 3'(a); wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input int a, output logic [15:0] v);
        @(negedge clk);
        rd_en = 1'b1; rd_addr = 3'(a);
        @(negedge clk);
        rd_en = 1'b0;
        v = rd_data;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    function automatic logic edge_ok(input int sel, input logic rising);
        return (sel == 3) || (sel == 1 && rising) || (sel == 2 && !rising);
    endfunction

    // count held after the most recent edge, clock mode, started at edge r
    function automatic logic [15:0] now_cnt();
        return 16'(cyc - r);
    endfunction

    task automatic run_cmp(input logic [15:0] d0, input logic [15:0] d1,
                           input logic [1:0] mode, input int ncyc);
        logic [15:0] v;
        logic [1:0]  eo, ei;
        int          bad0, bad1;
        wr(1, 16'h8000 | 16'(mode));
        wr(0, 16'h0000);
        wr(3, d0);
        wr(4, d1);
        rd(3, v);
        chk("R11 channel 0 readback", 32'(v), 32'(d0));
        wr(0, 16'h0001);
        r = cyc;
        eo = 2'b00; bad0 = 0; bad1 = 0;
        repeat (ncyc) begin
            @(negedge clk);
            ei[0] = !mode[0] && (cyc > r) && (now_cnt() == 16'(d0 + 1));
            ei[1] = !mode[1] && (cyc > r) && (now_cnt() == 16'(d1 + 1));
            eo = eo ^ ei;
            if (cmp_irq[0] !== ei[0] || cmp_out[0] !== eo[0]) bad0++;
            if (cmp_irq[1] !== ei[1] || cmp_out[1] !== eo[1]) bad1++;
        end
        if (mode[0]) chk("R10 channel 0 capture mode silent", 32'(bad0), 0);
        else         chk("R4 channel 0 compare window", 32'(bad0), 0);
        if (mode[1]) chk("R10 channel 1 capture mode silent", 32'(bad1), 0);
        else         chk("R4 channel 1 compare window", 32'(bad1), 0);
    endtask

    initial begin
        #(20ns * 190000);
        fails++;
        tests++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        logic [15:0] v, expv, d0, d1;
        logic [15:0] exp_cap [2];
        int p, ch, sel, n;
        logic rising;

        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 rd_data after reset", 32'(rd_data), 0);
        chk("R1 cmp_out after reset", 32'(cmp_out), 0);
        chk("R1 cmp_irq after reset", 32'(cmp_irq), 0);
        rd(2, v); chk("R1 count after reset", 32'(v), 0);
        rd(1, v); chk("R1 option after reset", 32'(v), 0);
        rd(4, v); chk("R1 channel 1 after reset", 32'(v), 0);

        // free-running count
        wr(0, 16'h0001);
        r = cyc;
        idle(10);
        rd(2, v);
        chk("R2 count readback", 32'(v), 32'(16'(cyc - 1 - r)));
        rd(0, v); chk("R11 control readback", 32'(v), 1);

        // hold at zero
        wr(0, 16'h0000);
        idle(3);
        rd(2, v); chk("R3 count held at zero", 32'(v), 0);

        // compare: directed, then random small values
        run_cmp(16'd5, 16'd9, 2'b00, 30);
        for (int k = 0; k < 3; k++) begin
            d0 = 16'($urandom % 40);
            d1 = 16'($urandom % 40);
            run_cmp(d0, d1, (k == 2) ? 2'b10 : 2'b00, 50);
        end
        // channel 0 toggled once, so its output is 1 here
        chk("R4 output left inverted", 32'(cmp_out[0]), 1);
        wr(0, 16'h0000);
        @(negedge clk);
        chk("R3 outputs cleared with run", 32'(cmp_out), 0);

        // random captures with random edge selects
        void'($urandom(32'd7));
        wr(1, 16'h8003);
        wr(3, 16'h0000);
        wr(4, 16'h0000);
        exp_cap[0] = 16'h0000; exp_cap[1] = 16'h0000;
        wr(0, 16'h0001);
        r = cyc;
        for (int k = 0; k < 14; k++) begin
            ch  = int'($urandom % 2);
            sel = int'($urandom % 4);
            wr(1, 16'h8003 | 16'(sel << (2 + 2 * ch)));
            idle(int'($urandom % 8));
            @(negedge clk);
            cap_pin[ch] = ~cap_pin[ch];
            rising = cap_pin[ch];
            p = cyc;
            idle(5);
            if (edge_ok(sel, rising)) exp_cap[ch] = 16'(p + 2 - r);
            rd(3 + ch, v);
            chk($sformatf("R5 R6 capture ch%0d sel%0d", ch, sel), 32'(v), 32'(exp_cap[ch]));
        end

        // capture and write on the same edge
        wr(1, 16'h800F);
        idle(2);
        @(negedge clk);
        cap_pin[0] = ~cap_pin[0];
        p = cyc;
        @(negedge clk);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = 3'd3; wr_data = 16'hABCD;
        @(negedge clk);
        wr_en = 1'b0;
        rd(3, v);
        chk("R9 capture beats write", 32'(v), 32'(16'(p + 2 - r)));
        wr(3, 16'h1234);
        rd(3, v); chk("R11 channel write readback", 32'(v), 32'h1234);

        // compare-mode channel ignores its pin
        wr(1, 16'h800C);
        wr(3, 16'h0777);
        @(negedge clk);
        cap_pin[0] = ~cap_pin[0];
        idle(5);
        rd(3, v); chk("R10 compare channel ignores pin", 32'(v), 32'h0777);

        // event counting for each edge select
        for (int s = 0; s < 4; s++) begin
            wr(0, 16'h0000);
            evt_pin = 1'b0;
            idle(3);
            wr(0, 16'h0003 | 16'(s << 2));
            n = 3 + int'($urandom % 4);
            repeat (n) begin
                evt_pin = 1'b1; idle(3);
                evt_pin = 1'b0; idle(3);
            end
            idle(4);
            rd(2, v);
            expv = (s == 0) ? 16'd0 : (s == 3) ? 16'(2 * n) : 16'(n);
            chk($sformatf("R7 R6 event count sel%0d", s), 32'(v), 32'(expv));
        end

        // overflow with a clearing write on the wrapping edge
        wr(0, 16'h0000);
        wr(1, 16'h8000);
        wr(4, 16'hFFFF);
        wr(3, 16'h0010);
        rd(1, v); chk("R8 flag clear before wrap", 32'(v[15]), 0);
        wr(0, 16'h0001);
        r = cyc;
        while (cyc < r + 65535) @(negedge clk);
        wr_en = 1'b1; wr_addr = 3'd1; wr_data = 16'h0000;
        @(negedge clk);
        wr_en = 1'b0;
        chk("R4 match at wrap for 0xFFFF", 32'(cmp_irq[1]), 1);
        rd(1, v); chk("R8 wrap beats clearing write", 32'(v[15]), 1);
        wr(1, 16'h8000);
        rd(1, v); chk("R8 writing 1 keeps flag", 32'(v[15]), 1);
        wr(1, 16'h0000);
        rd(1, v); chk("R8 writing 0 clears flag", 32'(v[15]), 0);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule